// File: doc/BRIEF.md
# Virtually Indexed, Physically Tagged Read Cache

This block is a direct-mapped read cache. Its set index comes entirely from the page-offset bits of the virtual byte address, and those bits pass through translation unchanged. The line array can therefore be read in the same clock cycle in which a small fully associative translation buffer converts the virtual page number into a physical frame number. At the next clock edge the block registers the stored line, its tag and valid bit, and the translation result. In the following cycle it compares the stored physical frame number against the translated frame number and returns hit, translation-miss and the requested byte.

The processor side presents a 20-bit virtual byte address with a one-cycle request strobe. Pages are 1 KB, so the low 10 bits are the page offset. Lines are 8 bytes and there are 128 of them: bits [2:0] select the byte and bits [9:3] select the line. The physical address is 16 bits wide, so each line's tag is the 6-bit frame number. A refill port writes one whole line together with its tag in a single cycle. A load port writes one translation slot. A flush clears every valid bit in both structures. The sizing rule (the cache holds no more bytes than one page) is checked when the design is elaborated, so two virtual names of one physical byte always select the same line.

The response controller is a two-state machine. In state IDLE no response is driven. The transition IDLE->RESP is taken on a request. RESP->RESP is taken on back-to-back requests. RESP->IDLE is taken when no request arrives. Outputs are driven only in RESP.

Top module: `vipt_cache`

## Requirements
- R1: After reset no response is driven, and every line and every translation slot is invalid. A lookup then reports tlb_miss=1. Once a translation has been loaded, a lookup through it reports hit=0 and tlb_miss=0 until the line has been refilled.
- R2: resp_valid is 1 in exactly the cycle after a cycle with req=1, and 0 otherwise. While resp_valid is 0, hit and tlb_miss are 0.
- R3: If no valid translation slot holds the virtual page number vaddr[19:10], the response has tlb_miss=1 and hit=0.
- R4: When the page number translates, the line selected by vaddr[9:3] is valid, and its stored tag equals the translated frame number, the response has hit=1, tlb_miss=0, and rdata equal to byte vaddr[2:0] of the line. Byte k of a line is fill_data[8k+7:8k].
- R5: When the translation hits but the stored tag of the selected line differs from the translated frame number, the response has hit=0 and tlb_miss=0.
- R6: Two virtual addresses with different page numbers that translate to the same frame number, and that have the same page offset, select the same line and return the same byte.
- R7: A refill with fill_en=1 writes all 8 bytes of line fill_line[6:0]. It stores fill_line[12:7] as the tag and sets the line valid. A request issued in the cycle right after the refill sees the new contents.
- R8: A load with tlb_wr_en=1 writes the page number and frame number into slot tlb_wr_slot, replacing that slot's previous mapping, and marks the slot valid.
- R9: A flush clears every cache valid bit and every translation valid bit in one cycle. A lookup right afterwards reports tlb_miss=1. After a translation is reloaded, its lines still miss.
- R10: The line count times the line size must not exceed the page size; a violating parameter set stops elaboration. With the default sizes, byte 7 of line 127 lies at page offset 0x3FF.
- R11: rdata is 0 in every cycle in which hit is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| req | input | 1 | Read request for vaddr in this cycle |
| vaddr | input | 20 | Virtual byte address |
| resp_valid | output | 1 | Response present (the cycle after req) |
| hit | output | 1 | Read hit |
| tlb_miss | output | 1 | Page number had no valid translation |
| rdata | output | 8 | Byte read on a hit, otherwise 0 |
| fill_en | input | 1 | Refill one line this cycle |
| fill_line | input | 13 | Physical line address: tag in [12:7], index in [6:0] |
| fill_data | input | 64 | Line contents, byte k in bits [8k+7:8k] |
| tlb_wr_en | input | 1 | Load one translation slot this cycle |
| tlb_wr_slot | input | 3 | Slot to load |
| tlb_wr_vpn | input | 10 | Virtual page number to install |
| tlb_wr_pfn | input | 6 | Physical frame number to install |
| flush | input | 1 | Invalidate all lines and all translations |

## Verification
The assertions assume that req, fill_en, tlb_wr_en and flush are mutually exclusive in any one cycle, and one property checks that contract directly. They also assume that no two valid translation slots hold the same page number. The stimulus issues each operation in its own cycle and gives every slot a distinct page number. Where two page numbers are meant to share a frame, they are given the same frame number deliberately. Expected bytes and tags come from a closed-form function of the line number and byte position. This lets the sweep over all 128 lines and all 8 byte positions be predicted without modelling the array.

// File: rtl/vipt_pkg.sv
package vipt_pkg;

    // Response controller states
    typedef enum logic [0:0] {
        ST_IDLE = 1'b0,
        ST_RESP = 1'b1
    } ctrl_state_e;

    // Default geometry shared by the modules
    localparam int unsigned DEF_VA_W      = 20;
    localparam int unsigned DEF_PA_W      = 16;
    localparam int unsigned DEF_PAGE_BITS = 10;
    localparam int unsigned DEF_LINE_B    = 8;
    localparam int unsigned DEF_LINES     = 128;
    localparam int unsigned DEF_TLB_N     = 8;

endpackage

// File: rtl/vipt_tlb.sv
module vipt_tlb #(
    parameter int unsigned VPN_W   = 10,
    parameter int unsigned PFN_W   = 6,
    parameter int unsigned ENTRIES = 8,
    localparam int unsigned SLOT_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              flush,
    input  logic              wr_en,
    input  logic [SLOT_W-1:0] wr_slot,
    input  logic [VPN_W-1:0]  wr_vpn,
    input  logic [PFN_W-1:0]  wr_pfn,
    input  logic [VPN_W-1:0]  lk_vpn,
    output logic              lk_hit,
    output logic [PFN_W-1:0]  lk_pfn
);

    logic [ENTRIES-1:0] slot_ok;
    logic [VPN_W-1:0]   slot_vpn [ENTRIES];
    logic [PFN_W-1:0]   slot_pfn [ENTRIES];
    logic [ENTRIES-1:0] match;

    // Valid bits: flush wins over a load in the same cycle
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            slot_ok <= '0;
        end else if (flush) begin
            slot_ok <= '0;
        end else if (wr_en) begin
            slot_ok[wr_slot] <= 1'b1;
        end
    end

    genvar g;
    generate
        for (g = 0; g < ENTRIES; g++) begin : g_slot
            always_ff @(posedge clk) begin
                if (wr_en && !flush && (wr_slot == SLOT_W'(g))) begin
                    slot_vpn[g] <= wr_vpn;
                    slot_pfn[g] <= wr_pfn;
                end
            end
            assign match[g] = slot_ok[g] && (slot_vpn[g] == lk_vpn);
        end
    endgenerate

    // Lowest matching slot wins
    always_comb begin
        lk_hit = |match;
        lk_pfn = '0;
        for (int e = ENTRIES - 1; e >= 0; e--) begin
            if (match[e]) begin
                lk_pfn = slot_pfn[e];
            end
        end
    end

endmodule

// File: rtl/vipt_line_store.sv
module vipt_line_store #(
    parameter int unsigned LINES     = 128,
    parameter int unsigned LINE_BITS = 64,
    parameter int unsigned TAG_W     = 6,
    localparam int unsigned IDX_W    = (LINES > 1) ? $clog2(LINES) : 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 flush,
    input  logic                 fill_en,
    input  logic [IDX_W-1:0]     fill_idx,
    input  logic [TAG_W-1:0]     fill_tag,
    input  logic [LINE_BITS-1:0] fill_data,
    input  logic [IDX_W-1:0]     rd_idx,
    output logic                 rd_valid,
    output logic [TAG_W-1:0]     rd_tag,
    output logic [LINE_BITS-1:0] rd_data
);

    logic [LINES-1:0]     line_ok;
    logic [TAG_W-1:0]     tag_mem  [LINES];
    logic [LINE_BITS-1:0] data_mem [LINES];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            line_ok <= '0;
        end else if (flush) begin
            line_ok <= '0;
        end else if (fill_en) begin
            line_ok[fill_idx] <= 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (fill_en && !flush) begin
            tag_mem[fill_idx]  <= fill_tag;
            data_mem[fill_idx] <= fill_data;
        end
    end

    // Read runs from the untranslated index in the lookup cycle
    assign rd_valid = line_ok[rd_idx];
    assign rd_tag   = tag_mem[rd_idx];
    assign rd_data  = data_mem[rd_idx];

endmodule

// File: rtl/vipt_ctrl.sv
module vipt_ctrl
    import vipt_pkg::*;
#(
    parameter int unsigned PFN_W      = 6,
    parameter int unsigned LINE_BYTES = 8,
    localparam int unsigned OFF_W     = (LINE_BYTES > 1) ? $clog2(LINE_BYTES) : 1,
    localparam int unsigned LINE_BITS = LINE_BYTES * 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 req,
    input  logic [OFF_W-1:0]     offset,
    input  logic                 tlb_hit,
    input  logic [PFN_W-1:0]     tlb_pfn,
    input  logic                 line_valid,
    input  logic [PFN_W-1:0]     line_tag,
    input  logic [LINE_BITS-1:0] line_data,
    output logic                 resp_valid,
    output logic                 hit,
    output logic                 tlb_miss,
    output logic [7:0]           rdata
);

    ctrl_state_e state_q, state_d;

    logic                 tlb_hit_q;
    logic [PFN_W-1:0]     pfn_q;
    logic                 valid_q;
    logic [PFN_W-1:0]     tag_q;
    logic [LINE_BITS-1:0] line_q;
    logic [OFF_W-1:0]     off_q;
    logic [7:0]           byte_sel;
    logic                 tag_eq;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (req)  state_d = ST_RESP;
            ST_RESP: if (!req) state_d = ST_IDLE;
            default:           state_d = ST_IDLE;
        endcase
    end

    // Capture both halves of the parallel lookup
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tlb_hit_q <= 1'b0;
            pfn_q     <= '0;
            valid_q   <= 1'b0;
            tag_q     <= '0;
            line_q    <= '0;
            off_q     <= '0;
        end else if (req) begin
            tlb_hit_q <= tlb_hit;
            pfn_q     <= tlb_pfn;
            valid_q   <= line_valid;
            tag_q     <= line_tag;
            line_q    <= line_data;
            off_q     <= offset;
        end
    end

    always_comb begin
        byte_sel = '0;
        for (int b = 0; b < LINE_BYTES; b++) begin
            if (off_q == OFF_W'(b)) begin
                byte_sel = line_q[b*8 +: 8];
            end
        end
    end

    assign tag_eq = (tag_q == pfn_q);

    // Outputs
    always_comb begin
        resp_valid = 1'b0;
        hit        = 1'b0;
        tlb_miss   = 1'b0;
        rdata      = '0;
        unique case (state_q)
            ST_IDLE: begin
            end
            ST_RESP: begin
                resp_valid = 1'b1;
                tlb_miss   = !tlb_hit_q;
                hit        = tlb_hit_q && valid_q && tag_eq;
                rdata      = (tlb_hit_q && valid_q && tag_eq) ? byte_sel : 8'h00;
            end
            default: begin
            end
        endcase
    end

endmodule

// File: rtl/vipt_cache.sv
module vipt_cache
    import vipt_pkg::*;
#(
    parameter int unsigned VA_W       = DEF_VA_W,
    parameter int unsigned PA_W       = DEF_PA_W,
    parameter int unsigned PAGE_BITS  = DEF_PAGE_BITS,
    parameter int unsigned LINE_BYTES = DEF_LINE_B,
    parameter int unsigned NUM_LINES  = DEF_LINES,
    parameter int unsigned TLB_N      = DEF_TLB_N,
    localparam int unsigned OFF_W     = $clog2(LINE_BYTES),
    localparam int unsigned IDX_W     = $clog2(NUM_LINES),
    localparam int unsigned VPN_W     = VA_W - PAGE_BITS,
    localparam int unsigned PFN_W     = PA_W - PAGE_BITS,
    localparam int unsigned LA_W      = PA_W - OFF_W,
    localparam int unsigned LINE_BITS = LINE_BYTES * 8,
    localparam int unsigned SLOT_W    = $clog2(TLB_N)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 req,
    input  logic [VA_W-1:0]      vaddr,
    output logic                 resp_valid,
    output logic                 hit,
    output logic                 tlb_miss,
    output logic [7:0]           rdata,
    input  logic                 fill_en,
    input  logic [LA_W-1:0]      fill_line,
    input  logic [LINE_BITS-1:0] fill_data,
    input  logic                 tlb_wr_en,
    input  logic [SLOT_W-1:0]    tlb_wr_slot,
    input  logic [VPN_W-1:0]     tlb_wr_vpn,
    input  logic [PFN_W-1:0]     tlb_wr_pfn,
    input  logic                 flush
);

    // R10: every index bit must lie inside the page offset
    generate
        if (NUM_LINES * LINE_BYTES > (2 ** PAGE_BITS)) begin : g_size_bad
            $error("cache larger than one page: index would need translated bits");
        end
    endgenerate

    logic                 tlb_hit;
    logic [PFN_W-1:0]     tlb_pfn;
    logic                 line_valid;
    logic [PFN_W-1:0]     line_tag;
    logic [LINE_BITS-1:0] line_data;
    logic [IDX_W-1:0]     look_idx;
    logic [VPN_W-1:0]     look_vpn;

    assign look_idx = vaddr[OFF_W +: IDX_W];
    assign look_vpn = vaddr[VA_W-1:PAGE_BITS];

    vipt_tlb #(
        .VPN_W   (VPN_W),
        .PFN_W   (PFN_W),
        .ENTRIES (TLB_N)
    ) u_tlb (
        .clk     (clk),
        .rst_n   (rst_n),
        .flush   (flush),
        .wr_en   (tlb_wr_en),
        .wr_slot (tlb_wr_slot),
        .wr_vpn  (tlb_wr_vpn),
        .wr_pfn  (tlb_wr_pfn),
        .lk_vpn  (look_vpn),
        .lk_hit  (tlb_hit),
        .lk_pfn  (tlb_pfn)
    );

    vipt_line_store #(
        .LINES     (NUM_LINES),
        .LINE_BITS (LINE_BITS),
        .TAG_W     (PFN_W)
    ) u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .flush     (flush),
        .fill_en   (fill_en),
        .fill_idx  (fill_line[IDX_W-1:0]),
        .fill_tag  (fill_line[LA_W-1:PAGE_BITS-OFF_W]),
        .fill_data (fill_data),
        .rd_idx    (look_idx),
        .rd_valid  (line_valid),
        .rd_tag    (line_tag),
        .rd_data   (line_data)
    );

    vipt_ctrl #(
        .PFN_W      (PFN_W),
        .LINE_BYTES (LINE_BYTES)
    ) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .req        (req),
        .offset     (vaddr[OFF_W-1:0]),
        .tlb_hit    (tlb_hit),
        .tlb_pfn    (tlb_pfn),
        .line_valid (line_valid),
        .line_tag   (line_tag),
        .line_data  (line_data),
        .resp_valid (resp_valid),
        .hit        (hit),
        .tlb_miss   (tlb_miss),
        .rdata      (rdata)
    );

endmodule

// File: rtl/vipt_cache_chk.sv
module vipt_cache_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       req,
    input logic       flush,
    input logic       fill_en,
    input logic       tlb_wr_en,
    input logic       resp_valid,
    input logic       hit,
    input logic       tlb_miss,
    input logic [7:0] rdata
);

    // R2: a response follows every request
    p_resp_after_req_r2: assert property (@(posedge clk) disable iff (!rst_n)
        req |=> resp_valid);

    // R2: no response without a request
    p_no_spurious_resp_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !req |=> !resp_valid);

    // R2: hit and tlb_miss stay low outside a response
    p_quiet_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !resp_valid |-> (!hit && !tlb_miss));

    // R3: a translation miss never reports a hit
    p_tlbmiss_no_hit_r3: assert property (@(posedge clk) disable iff (!rst_n)
        tlb_miss |-> !hit);

    // R9: a lookup right after a flush has no translation
    p_flush_empties_tlb_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (req && $past(flush) && !tlb_wr_en) |=> tlb_miss);

    // R11: data is zero unless the response hits
    p_zero_on_miss_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !hit |-> (rdata == 8'h00));

    // R9: operations arrive one per cycle (input contract)
    p_single_op_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({req, flush, fill_en, tlb_wr_en}));

endmodule

bind vipt_cache vipt_cache_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .req        (req),
    .flush      (flush),
    .fill_en    (fill_en),
    .tlb_wr_en  (tlb_wr_en),
    .resp_valid (resp_valid),
    .hit        (hit),
    .tlb_miss   (tlb_miss),
    .rdata      (rdata)
);

// File: tb/vipt_cache_test.sv
`timescale 1ns/1ps
module vipt_cache_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req = 1'b0;
    logic [19:0] vaddr = '0;
    logic        resp_valid, hit, tlb_miss;
    logic [7:0]  rdata;
    logic        fill_en = 1'b0;
    logic [12:0] fill_line = '0;
    logic [63:0] fill_data = '0;
    logic        tlb_wr_en = 1'b0;
    logic [2:0]  tlb_wr_slot = '0;
    logic [9:0]  tlb_wr_vpn = '0;
    logic [5:0]  tlb_wr_pfn = '0;
    logic        flush = 1'b0;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    vipt_cache uut (
        .clk(clk), .rst_n(rst_n), .req(req), .vaddr(vaddr),
        .resp_valid(resp_valid), .hit(hit), .tlb_miss(tlb_miss), .rdata(rdata),
        .fill_en(fill_en), .fill_line(fill_line), .fill_data(fill_data),
        .tlb_wr_en(tlb_wr_en), .tlb_wr_slot(tlb_wr_slot),
        .tlb_wr_vpn(tlb_wr_vpn), .tlb_wr_pfn(tlb_wr_pfn), .flush(flush)
    );

    function automatic logic [9:0] vpn_of(input int s);
        return 10'(s * 37 + 5);
    endfunction

    // Slot 7 aliases slot 0's frame
    function automatic logic [5:0] pfn_of(input int s);
        return (s == 7) ? 6'd2 : 6'(s * 9 + 2);
    endfunction

    function automatic logic [7:0] byte_of(input int i, input int k, input int seed);
        return 8'((i * 8 + k) * 29 + 17 + seed);
    endfunction

    function automatic logic [63:0] line_of(input int i, input int seed);
        logic [63:0] d;
        for (int k = 0; k < 8; k++) d[k*8 +: 8] = byte_of(i, k, seed);
        return d;
    endfunction

    task automatic check(input string rq, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", rq, what, act, exp);
        end
    endtask

    task automatic tlb_load(input int slot, input logic [9:0] vpn, input logic [5:0] pfn);
        @(negedge clk);
        tlb_wr_en = 1'b1; tlb_wr_slot = 3'(slot); tlb_wr_vpn = vpn; tlb_wr_pfn = pfn;
        @(negedge clk);
        tlb_wr_en = 1'b0;
    endtask

    task automatic refill(input logic [5:0] tag, input int idx, input logic [63:0] d);
        @(negedge clk);
        fill_en = 1'b1; fill_line = {tag, 7'(idx)}; fill_data = d;
        @(negedge clk);
        fill_en = 1'b0;
    endtask

    // Request at one negedge, sample the response at the next
    task automatic lookup(input logic [19:0] va);
        @(negedge clk);
        req = 1'b1; vaddr = va;
        @(negedge clk);
        req = 1'b0;
    endtask

    task automatic expect_resp(input string rq, input logic h, input logic tm, input logic [7:0] d);
        check(rq, "resp_valid", 32'(resp_valid), 32'd1);
        check(rq, "hit", 32'(hit), 32'(h));
        check(rq, "tlb_miss", 32'(tlb_miss), 32'(tm));
        check(rq, "rdata", 32'(rdata), 32'(d));
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL R2 watchdog: actual=timeout expected=completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        check("R1", "resp_valid after reset", 32'(resp_valid), 32'd0);
        check("R1", "hit after reset", 32'(hit), 32'd0);
        lookup({vpn_of(0), 7'd0, 3'd0});
        expect_resp("R1", 1'b0, 1'b1, 8'h00);

        // Load translations; lines are still invalid (R1)
        for (int s = 0; s < 8; s++) tlb_load(s, vpn_of(s), pfn_of(s));
        lookup({vpn_of(3), 7'd40, 3'd1});
        expect_resp("R1", 1'b0, 1'b0, 8'h00);

        // Refill every line, tag taken from slot (i mod 7)
        for (int i = 0; i < 128; i++) refill(pfn_of(i % 7), i, line_of(i, 0));

        // R4: full sweep of lines and byte positions
        for (int i = 0; i < 128; i++) begin
            for (int k = 0; k < 8; k++) begin
                lookup({vpn_of(i % 7), 7'(i), 3'(k)});
                expect_resp("R4", 1'b1, 1'b0, byte_of(i, k, 0));
            end
        end
        // R10: last byte of the last line sits at page offset 0x3FF
        lookup({vpn_of(127 % 7), 10'h3FF});
        expect_resp("R10", 1'b1, 1'b0, byte_of(127, 7, 0));
        // R2: no request, no response
        @(negedge clk);
        check("R2", "resp_valid idle", 32'(resp_valid), 32'd0);
        check("R2", "tlb_miss idle", 32'(tlb_miss), 32'd0);

        // R6: synonym page through slot 7 shares the frame of slot 0
        for (int i = 0; i < 128; i += 7) begin
            lookup({vpn_of(7), 7'(i), 3'(i % 8)});
            expect_resp("R6", 1'b1, 1'b0, byte_of(i, i % 8, 0));
        end

        // R5 and R11: translated frame differs from stored tag
        for (int i = 0; i < 128; i += 5) begin
            lookup({vpn_of((i % 7 + 1) % 7), 7'(i), 3'd2});
            expect_resp("R5", 1'b0, 1'b0, 8'h00);
        end

        // R3: unmapped page numbers
        for (int i = 0; i < 128; i += 31) begin
            lookup({10'd1000, 7'(i), 3'd0});
            expect_resp("R3", 1'b0, 1'b1, 8'h00);
        end

        // R8: slot 1 now maps to slot 2's frame
        tlb_load(1, vpn_of(1), pfn_of(2));
        lookup({vpn_of(1), 7'd2, 3'd5});
        expect_resp("R8", 1'b1, 1'b0, byte_of(2, 5, 0));
        lookup({vpn_of(1), 7'd1, 3'd5});
        expect_resp("R8", 1'b0, 1'b0, 8'h00);

        // R7: refill then request in the very next cycle
        tlb_load(3, vpn_of(3), 6'd63);
        @(negedge clk);
        fill_en = 1'b1; fill_line = {6'd63, 7'd9}; fill_data = line_of(9, 100);
        @(negedge clk);
        fill_en = 1'b0; req = 1'b1; vaddr = {vpn_of(3), 7'd9, 3'd6};
        @(negedge clk);
        req = 1'b0;
        expect_resp("R7", 1'b1, 1'b0, byte_of(9, 6, 100));
        for (int k = 0; k < 8; k++) begin
            lookup({vpn_of(3), 7'd9, 3'(k)});
            expect_resp("R7", 1'b1, 1'b0, byte_of(9, k, 100));
        end

        // R2: back-to-back requests keep responding each cycle
        @(negedge clk);
        req = 1'b1; vaddr = {vpn_of(0), 7'd0, 3'd0};
        @(negedge clk);
        vaddr = {vpn_of(0), 7'd7, 3'd1};
        expect_resp("R2", 1'b1, 1'b0, byte_of(0, 0, 0));
        @(negedge clk);
        req = 1'b0;
        expect_resp("R2", 1'b1, 1'b0, byte_of(7, 1, 0));

        // R9: flush clears both structures
        @(negedge clk);
        flush = 1'b1;
        @(negedge clk);
        flush = 1'b0; req = 1'b1; vaddr = {vpn_of(0), 7'd0, 3'd0};
        @(negedge clk);
        req = 1'b0;
        expect_resp("R9", 1'b0, 1'b1, 8'h00);
        tlb_load(0, vpn_of(0), pfn_of(0));
        lookup({vpn_of(0), 7'd0, 3'd0});
        expect_resp("R9", 1'b0, 1'b0, 8'h00);
        lookup({vpn_of(0), 7'd70, 3'd3});
        expect_resp("R9", 1'b0, 1'b0, 8'h00);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule